// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets clocked logic read and write an 8192-word by 8-bit asynchronous static RAM. A user pulses `req` for one cycle with a direction flag, a 13-bit word address and, for a write, a byte of data. The block then runs the memory's strobes for a whole access and pulses `rsp_done` once at the end. For a read, the captured byte appears on `rsp_rdata` in the same cycle as `rsp_done`.

Every strobe duration comes from a cycle count. Each count is a nanosecond limit divided by `CLK_PERIOD_NS` and rounded up. A read keeps both selects and output enable active until the slowest of three limits has passed: the 85 ns address-to-data time, the 85 ns minimum cycle and the 45 ns output-enable-to-data time. Only then is the bus sampled. A write can end in one of two ways, chosen by the `END_ON_SEL` parameter:
- **Write-enable edge (0):** write enable is released first and the selects are held one cycle longer.
- **Select edge (1):** write enable leads by one cycle and the selects and write enable are released together.

Each way has its own minimum duration for write enable, selects and data setup. All pin outputs come straight from flops. Requests that arrive while an access is running are dropped.

Top module: `async_sram_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, every strobe goes inactive and `rsp_done` goes low after that edge: `mem_sel_n`=1, `mem_sel`=0, `mem_rd_n`=1, `mem_wr_n`=1.
- R2: A read keeps selects and `mem_rd_n` active for exactly N_RD = max(ceil(85/P), ceil(45/P)) cycles (9 at P=10 ns). It samples `mem_d` at the edge that ends that window, so `rsp_rdata` equals the byte last written at that address.
- R3: The accepting edge is number 0. `rsp_done` is high in the cycle after rising edge N+1, where N is N_RD for a read and N_WR for a write.
- R4: With `END_ON_SEL`=0, `mem_wr_n` is low for N_WR = max(ceil(55/P), ceil(75/P), ceil(40/P), ceil(85/P)-1) cycles (8 at 10 ns). The selects cover that window and stay active one cycle after `mem_wr_n` rises, for a 9-cycle access.
- R5: With `END_ON_SEL`=1, `mem_wr_n` is low for N_WR = max(ceil(55/P), 1+ceil(75/P), ceil(40/P), ceil(85/P)) cycles (9 at 10 ns). The selects are active in all of those cycles except the first (8 cycles), and selects and `mem_wr_n` return inactive at the same edge.
- R6: During a write, `mem_d` carries the request's data, unchanged, for every cycle in which selects and write enable overlap, which is at least ceil(40/P) cycles. A later read of that address returns it.
- R7: A `req` seen while an access is in progress starts no memory access, stores nothing and produces no `rsp_done`.
- R8: `rsp_done` is high for exactly one cycle per accepted request.
- R9: `mem_a` holds the accepted address unchanged while the selects stay active. Addresses 0 and 8191 both work.
- R10: `mem_rd_n` and `mem_wr_n` are never low together.
- R11: The two selects always agree: `mem_sel_n` is the inverse of `mem_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, period `CLK_PERIOD_NS` |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | One-cycle access request, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Byte captured by the last read |
| rsp_done | output | 1 | One-cycle end-of-access strobe |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_sel | output | 1 | Memory select, active high |
| mem_rd_n | output | 1 | Memory output enable, active low |
| mem_wr_n | output | 1 | Memory write enable, active low |
| mem_a | output | 13 | Memory address bus |
| mem_d | inout | 8 | Memory data bus, driven by the block only during writes |

## Verification
The memory model returns the inverted byte until selects and output enable have been active long enough. A sequencer that samples one cycle early therefore reads corrupted data rather than passing by luck. The model measures each write-enable, select-overlap and data-stable window and records whether the selects fall with write enable. A miscounted pulse, or an end-of-write mode swapped with the other, changes those widths or that flag. A request pulsed in the middle of an access must leave the write count and a previously stored byte untouched; a design that accepts it writes a second time or raises a second done. The extreme addresses 0 and 8191 catch a truncated address path.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the static RAM access sequencer.
// Assumes all timing arguments are positive nanosecond values.
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_READ_WAIT   = 2'd1,
        ST_WRITE_PULSE = 2'd2,
        ST_RECOVER     = 2'd3
    } seq_state_e;

    // Whole clock cycles needed to cover a nanosecond limit.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
// Loadable down counter that times one phase of an access.
// Assumes load and count-down never need to happen in the same cycle.
module sram_cycle_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load a phase length, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_access_fsm.sv
`timescale 1ns/1ps
// Access sequencer: accepts one request when idle and walks it through
// a timed strobe phase and a one-cycle recovery phase.
// Produces unregistered strobe requests; the pin stage registers them,
// so every pin lags the state by exactly one cycle.
// Assumes RD_CYC and WR_CYC are at least 1.
module sram_access_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned RD_CYC     = 9,
    parameter int unsigned WR_CYC     = 8,
    parameter bit          END_ON_SEL = 1'b0,
    parameter int unsigned CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             sel_req,
    output logic             rd_req,
    output logic             wr_req,
    output logic             drive_req,
    output logic             cap_req,
    output logic             done_req
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);

    seq_state_e st_q, st_nxt;
    logic       op_wr_q;
    logic       wr_first;
    logic       in_rd, in_wr, in_rec;

    // Next state and timer load.
    always_comb begin
        st_nxt   = st_q;
        accept   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_wr) begin
                        st_nxt  = ST_WRITE_PULSE;
                        tmr_val = WR_LOAD;
                    end else begin
                        st_nxt  = ST_READ_WAIT;
                        tmr_val = RD_LOAD;
                    end
                end
            end
            ST_READ_WAIT, ST_WRITE_PULSE: begin
                if (tmr_expired) st_nxt = ST_RECOVER;
            end
            ST_RECOVER: st_nxt = ST_IDLE;
            default:    st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // Remember the direction of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)      op_wr_q <= 1'b0;
        else if (accept) op_wr_q <= req_wr;
    end

    assign in_rd    = (st_q == ST_READ_WAIT);
    assign in_wr    = (st_q == ST_WRITE_PULSE);
    assign in_rec   = (st_q == ST_RECOVER);
    assign wr_first = in_wr && (tmr_cnt == WR_LOAD);

    // Strobe requests; the end-of-write mode shapes the select window.
    always_comb begin
        rd_req    = in_rd;
        wr_req    = in_wr;
        sel_req   = in_rd
                  || (in_wr && !(END_ON_SEL && wr_first))
                  || (in_rec && op_wr_q && !END_ON_SEL);
        drive_req = in_wr || (in_rec && op_wr_q && !END_ON_SEL);
        cap_req   = in_rec && !op_wr_q;
        done_req  = in_rec;
    end

endmodule

// File: rtl/sram_pin_stage.sv
`timescale 1ns/1ps
// Output flops for every memory pin and the user response, plus the
// tri-state data driver and the read capture register.
// Assumes strobe requests arrive one cycle ahead of the pins.
module sram_pin_stage #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              sel_req,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              drive_req,
    input  logic              cap_req,
    input  logic              done_req,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [ADDR_W-1:0] mem_a,
    inout  wire  [DATA_W-1:0] mem_d,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done
);

    logic              sel_q, rd_q, wr_q, drv_q, done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    // Register the strobes so the pins are glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            drv_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            sel_q  <= sel_req;
            rd_q   <= rd_req;
            wr_q   <= wr_req;
            drv_q  <= drive_req;
            done_q <= done_req;
        end
    end

    // Latch address and write data when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    // Capture the bus at the edge that closes the read window.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (cap_req) rdata_q <= mem_d;
    end

    assign mem_sel_n = !sel_q;
    assign mem_sel   = sel_q;
    assign mem_rd_n  = !rd_q;
    assign mem_wr_n  = !wr_q;
    assign mem_a     = addr_q;
    assign mem_d     = drv_q ? wdata_q : 'z;
    assign rsp_rdata = rdata_q;
    assign rsp_done  = done_q;

endmodule

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
// Synchronous front end for an 8K x 8 asynchronous static RAM.
// Derives every strobe width from CLK_PERIOD_NS and nanosecond limits,
// rounding each up to whole cycles. Assumes one access at a time.
module async_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_RCYC_NS     = 85,
    parameter int unsigned T_ADATA_NS    = 85,
    parameter int unsigned T_OEDATA_NS   = 45,
    parameter int unsigned T_WCYC_NS     = 85,
    parameter int unsigned T_WPULSE_NS   = 55,
    parameter int unsigned T_SELEND_NS   = 75,
    parameter int unsigned T_DSETUP_NS   = 40,
    parameter bit          END_ON_SEL    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [ADDR_W-1:0] mem_a,
    inout  wire  [DATA_W-1:0] mem_d
);

    localparam int unsigned C_RCYC  = ns_to_cyc(T_RCYC_NS,   CLK_PERIOD_NS);
    localparam int unsigned C_ADATA = ns_to_cyc(T_ADATA_NS,  CLK_PERIOD_NS);
    localparam int unsigned C_OE    = ns_to_cyc(T_OEDATA_NS, CLK_PERIOD_NS);
    localparam int unsigned C_WCYC  = ns_to_cyc(T_WCYC_NS,   CLK_PERIOD_NS);
    localparam int unsigned C_WP    = ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS);
    localparam int unsigned C_SEL   = ns_to_cyc(T_SELEND_NS, CLK_PERIOD_NS);
    localparam int unsigned C_DS    = ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned RD_CYC  = max_u(max_u(C_RCYC, C_ADATA), max_u(C_OE, 1));
    // Write-enable ending: selects run one extra cycle that counts toward the cycle time.
    localparam int unsigned WR_WE   = max_u(max_u(C_WP, C_SEL), max_u(C_DS, max_u(C_WCYC - 1, 1)));
    // Select ending: write enable leads the selects by one setup cycle.
    localparam int unsigned WR_SEL  = max_u(max_u(C_WP, C_SEL + 1), max_u(C_DS + 1, C_WCYC));
    localparam int unsigned WR_CYC  = END_ON_SEL ? WR_SEL : WR_WE;
    localparam int unsigned CNT_W   = $clog2(max_u(RD_CYC, WR_CYC) + 1);

    logic             tmr_load, tmr_expired, accept;
    logic [CNT_W-1:0] tmr_val, tmr_cnt;
    logic             sel_req, rd_req, wr_req, drive_req, cap_req, done_req;

    sram_cycle_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .expired  (tmr_expired)
    );

    sram_access_fsm #(
        .RD_CYC     (RD_CYC),
        .WR_CYC     (WR_CYC),
        .END_ON_SEL (END_ON_SEL),
        .CNT_W      (CNT_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_wr      (req_wr),
        .tmr_cnt     (tmr_cnt),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .accept      (accept),
        .sel_req     (sel_req),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .drive_req   (drive_req),
        .cap_req     (cap_req),
        .done_req    (done_req)
    );

    sram_pin_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .addr_in   (req_addr),
        .wdata_in  (req_wdata),
        .sel_req   (sel_req),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .drive_req (drive_req),
        .cap_req   (cap_req),
        .done_req  (done_req),
        .mem_sel_n (mem_sel_n),
        .mem_sel   (mem_sel),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n),
        .mem_a     (mem_a),
        .mem_d     (mem_d),
        .rsp_rdata (rsp_rdata),
        .rsp_done  (rsp_done)
    );

endmodule

// File: rtl/async_sram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the static RAM access sequencer, bound to its top.
module async_sram_ctrl_chk #(
    parameter int unsigned ADDR_W     = 13,
    parameter bit          END_ON_SEL = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_done,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic [ADDR_W-1:0] mem_a
);

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (mem_sel_n && !mem_sel && mem_rd_n && mem_wr_n && !rsp_done));

    a_r11_sel_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n == !mem_sel);

    a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_a));

    generate
        if (END_ON_SEL) begin : g_sel_end
            a_r5_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_wr_n) |-> mem_sel_n);
        end else begin : g_we_end
            a_r4_sel_outlasts_we: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_wr_n) |-> !mem_sel_n);
        end
    endgenerate

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .END_ON_SEL (END_ON_SEL)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_done  (rsp_done),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_a     (mem_a)
);

// File: tb/sram_model.sv
`timescale 1ns/1ps
// Behavioural 8K x 8 static RAM that measures strobe windows in clock
// cycles (sampled on the falling edge) and returns inverted data until
// the read access time has elapsed.
module sram_model #(
    parameter int RD_NEED = 9
) (
    input  logic        clk,
    input  logic        sel_n,
    input  logic        sel,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [12:0] a,
    inout  wire  [7:0]  d,
    output int          we_len,
    output int          ovl_len,
    output int          cyc_len,
    output int          rd_len,
    output int          dset_len,
    output int          wr_count,
    output logic        joint_end
);

    logic [7:0] mem [int unsigned];
    logic [7:0] rd_val = 8'h00;
    logic [7:0] d_prev = 8'h00;
    logic [12:0] a_prev = '0;
    logic       in_wr_prev = 1'b0;
    int we_c = 0, ovl_c = 0, cyc_c = 0, rd_c = 0, dst_c = 0;

    logic sel_on, rd_act;
    assign sel_on = !sel_n && sel;
    assign rd_act = sel_on && !rd_n && wr_n;
    assign d = rd_act ? ((rd_c >= RD_NEED) ? rd_val : ~rd_val) : 'z;

    initial begin
        we_len = 0; ovl_len = 0; cyc_len = 0; rd_len = 0;
        dset_len = 0; wr_count = 0; joint_end = 1'b0;
    end

    always @(negedge clk) begin
        if (!wr_n) we_c++;
        else if (we_c != 0) begin we_len = we_c; we_c = 0; end
        if (sel_on && !wr_n) begin
            if (ovl_c != 0 && d == d_prev) dst_c++;
            else dst_c = 1;
            ovl_c++;
            d_prev = d;
            a_prev = a;
        end
        if (in_wr_prev && !(sel_on && !wr_n)) begin
            mem[int'(a_prev)] = d_prev;
            wr_count++;
            ovl_len = ovl_c;
            ovl_c = 0;
            dset_len = dst_c;
            joint_end = !sel_on && wr_n;
        end
        in_wr_prev = sel_on && !wr_n;
        if (sel_on || !wr_n || !rd_n) cyc_c++;
        else if (cyc_c != 0) begin cyc_len = cyc_c; cyc_c = 0; end
        if (rd_act) begin
            rd_c++;
            rd_val = mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
        end else if (rd_c != 0) begin
            rd_len = rd_c;
            rd_c = 0;
        end
    end

endmodule

// File: tb/async_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench: two sequencers (write-enable ending and select ending)
// share one request stream, each with its own memory model.
module async_sram_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_wr = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;

    logic [7:0]  rdata0, rdata1;
    logic        done0, done1;
    logic        seln0, sel0, rdn0, wrn0, seln1, sel1, rdn1, wrn1;
    logic [12:0] a0, a1;
    wire  [7:0]  d0, d1;

    int we0, ovl0, cyc0, rdl0, ds0, wc0, we1, ovl1, cyc1, rdl1, ds1, wc1;
    logic je0, je1;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    async_sram_ctrl #(.END_ON_SEL(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rdata0), .rsp_done(done0),
        .mem_sel_n(seln0), .mem_sel(sel0), .mem_rd_n(rdn0), .mem_wr_n(wrn0),
        .mem_a(a0), .mem_d(d0)
    );

    async_sram_ctrl #(.END_ON_SEL(1'b1)) dut_cs_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rdata1), .rsp_done(done1),
        .mem_sel_n(seln1), .mem_sel(sel1), .mem_rd_n(rdn1), .mem_wr_n(wrn1),
        .mem_a(a1), .mem_d(d1)
    );

    sram_model mdl0 (
        .clk(clk), .sel_n(seln0), .sel(sel0), .rd_n(rdn0), .wr_n(wrn0), .a(a0), .d(d0),
        .we_len(we0), .ovl_len(ovl0), .cyc_len(cyc0), .rd_len(rdl0),
        .dset_len(ds0), .wr_count(wc0), .joint_end(je0)
    );

    sram_model mdl1 (
        .clk(clk), .sel_n(seln1), .sel(sel1), .rd_n(rdn1), .wr_n(wrn1), .a(a1), .d(d1),
        .we_len(we1), .ovl_len(ovl1), .cyc_len(cyc1), .rd_len(rdl1),
        .dset_len(ds1), .wr_count(wc1), .joint_end(je1)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One access on both sequencers; optional stray request mid-access.
    task automatic run_access(input logic w, input logic [12:0] adr, input logic [7:0] dat,
                              input logic stray, output int lat0, output int lat1,
                              output int cnt0, output int cnt1);
        lat0 = 0; lat1 = 0; cnt0 = 0; cnt1 = 0;
        @(negedge clk);
        req = 1'b1; req_wr = w; req_addr = adr; req_wdata = dat;
        for (int n = 1; n <= 24; n++) begin
            @(negedge clk);
            req = 1'b0;
            if (stray && n == 3) begin
                req = 1'b1; req_wr = 1'b1; req_addr = 13'h0AAA; req_wdata = 8'hEE;
            end
            if (done0) begin cnt0++; if (lat0 == 0) lat0 = n; end
            if (done1) begin cnt1++; if (lat1 == 0) lat1 = n; end
        end
        req = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 sel_n idle", int'(seln0 & seln1), 1);
        check("R1 sel idle", int'(sel0 | sel1), 0);
        check("R1 rd_n idle", int'(rdn0 & rdn1), 1);
        check("R1 wr_n idle", int'(wrn0 & wrn1), 1);
        check("R1 done low", int'(done0 | done1), 0);
        check("R11 select pair agree", int'(seln0 == !sel0 && seln1 == !sel1), 1);
    endtask

    task automatic t_write(input logic [12:0] adr, input logic [7:0] dat);
        int l0, l1, c0, c1;
        run_access(1'b1, adr, dat, 1'b0, l0, l1, c0, c1);
        check("R3 write done latency we-end", l0, 10);
        check("R3 write done latency sel-end", l1, 11);
        check("R8 single done we-end", c0, 1);
        check("R8 single done sel-end", c1, 1);
        check("R4 we low cycles", we0, 8);
        check("R4 sel/we overlap cycles", ovl0, 8);
        check("R4 access cycles", cyc0, 9);
        check("R4 sel outlasts we", int'(je0), 0);
        check("R5 we low cycles", we1, 9);
        check("R5 sel/we overlap cycles", ovl1, 8);
        check("R5 access cycles", cyc1, 9);
        check("R5 sel and we end together", int'(je1), 1);
        check("R6 data setup we-end", int'(ds0 >= 4 && ds0 == ovl0), 1);
        check("R6 data setup sel-end", int'(ds1 >= 4 && ds1 == ovl1), 1);
    endtask

    task automatic t_read(input logic [12:0] adr, input logic [7:0] exp);
        int l0, l1, c0, c1;
        run_access(1'b0, adr, 8'h00, 1'b0, l0, l1, c0, c1);
        check("R3 read done latency we-end", l0, 11);
        check("R3 read done latency sel-end", l1, 11);
        check("R8 single done read", c0 + c1, 2);
        check("R2 read window cycles", rdl0, 9);
        check("R2 read window cycles sel-end", rdl1, 9);
        check($sformatf("R2 R9 read data @%0h", adr), int'(rdata0), int'(exp));
        check($sformatf("R2 R9 read data sel-end @%0h", adr), int'(rdata1), int'(exp));
    endtask

    task automatic t_busy_ignore();
        int l0, l1, c0, c1, w0, w1;
        w0 = wc0; w1 = wc1;
        run_access(1'b1, 13'h0123, 8'h77, 1'b1, l0, l1, c0, c1);
        check("R7 one done despite stray req", c0, 1);
        check("R7 one done despite stray req sel-end", c1, 1);
        check("R7 one store", wc0 - w0, 1);
        check("R7 one store sel-end", wc1 - w1, 1);
        t_read(13'h0AAA, 8'h5A);
        t_read(13'h0123, 8'h77);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_write(13'h0000, 8'h3C);
        t_write(13'h1FFF, 8'hC3);
        t_write(13'h0AAA, 8'h5A);
        t_write(13'h1555, 8'hA5);
        t_read(13'h0000, 8'h3C);
        t_read(13'h1FFF, 8'hC3);
        t_read(13'h1555, 8'hA5);
        t_read(13'h0AAA, 8'h5A);
        t_busy_ignore();
        t_write(13'h1555, 8'hFF);
        t_read(13'h1555, 8'hFF);
        t_read(13'h0000, 8'h3C);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule